// File: doc/BRIEF.md
# GPIO Interrupt Channel Router

This block picks up to eight pads out of a 62-wide pad input vector. It turns each picked pad into an interrupt line whose trigger condition is set by software. Each of the eight channels has two parts: a pad-select crossbar entry, and a trigger decoder. The decoder can be level-sensitive, single-edge or both-edge, and its polarity can be inverted. One master enable bit gates all eight lines at the same time.

Software programs the block through a small word-addressed register window. There is one control word, plus four pad-select words that each hold two channels. Every write carries a per-bit write mask. This lets one channel be reconfigured without a read-modify-write of the other channels' bits. Pads pass through a two-flop synchroniser before they are decoded, and every interrupt line is driven from a register.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset, every register reads zero and all eight interrupt outputs are low.
- R2: While control bit 31 (master enable) is 0, all eight interrupt outputs are 0.
- R3: Level mode is selected when the both-edge bit (control bit 16+n) and the edge bit (control bit 8+n) of channel n are both 0. In level mode the output is 1 while the selected pad is 1. When the polarity bit (control bit n) is set, the output is 1 while the selected pad is 0 instead.
- R4: Single-edge mode is selected when the edge bit is 1 and the both-edge bit is 0. In this mode the output gives a one-cycle pulse on each rising edge of the pad, or on each falling edge when the polarity bit is 1.
- R5: When the both-edge bit is 1, the output pulses for one cycle on every transition of the pad, whatever the edge and polarity bits hold.
- R6: The 7-bit pad index of channel n is held at byte address 0x04 + (n/2)*4. Even channels use bits 6:0 and odd channels use bits 22:16. The channel follows the pad with that index.
- R7: A pad index of 62 or higher selects a constant-low source, and that channel never fires in any mode.
- R8: A write changes only the bits whose write-mask bit is 1. All other bits keep their value.
- R9: Unimplemented bits read as 0. The control word implements bits 31 and 23:0, and a select word implements bits 22:16 and 6:0. Addresses outside 0x00..0x10 read 0. Read data appears one cycle after the address is presented.
- R10: A pad change made before clock edge k shows on the output after edge k+2, which is two synchroniser stages plus the output register.
- R11: A write that touches any of a channel's configuration bits blocks edge detection on that channel for the next cycle. As a result, moving a channel to a pad at a different level produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_in | input | 62 | Asynchronous pad levels |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_wmask | input | 32 | Per-bit write enable |
| bus_rdata | output | 32 | Read data, registered |
| irq_out | output | 8 | Interrupt lines, one per channel |

## Verification
Two events can land in the same cycle: a configuration write to a channel, and a synchronised pad transition seen by that channel's edge detector. The bench sets this up by moving a rising-edge channel from a low pad to a high pad. Without the suppression cycle, the switch would look like an edge. The outputs must stay low for several cycles afterwards. A second collision, clearing the master enable while a level channel is active, is judged by all outputs going low within the register latency.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned NUM_PADS  = 62;
  localparam int unsigned NUM_CH    = 8;
  localparam int unsigned SEL_W     = 7;
  localparam int unsigned ADDR_W    = 5;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned EN_BIT    = 31;
  localparam int unsigned POL_LSB   = 0;
  localparam int unsigned EDGE_LSB  = 8;
  localparam int unsigned BOTH_LSB  = 16;
  localparam int unsigned SEL_BASE  = 4;
  localparam int unsigned ODD_LSB   = 16;
endpackage

// File: rtl/irq_pad_sync.sv
module irq_pad_sync #(
  parameter int unsigned WIDTH = 62
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NCH  = NUM_CH,
  parameter int unsigned SELW = SEL_W,
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned DW   = DATA_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  input  logic [DW-1:0]        wmask,
  output logic [DW-1:0]        rdata,
  output logic                 en,
  output logic [NCH-1:0]       both,
  output logic [NCH-1:0]       edg,
  output logic [NCH-1:0]       pol,
  output logic [NCH-1:0][SELW-1:0] sel,
  output logic [NCH-1:0]       touch
);
  logic ctrl_hit;
  logic [DW-1:0] rd_next;

  assign ctrl_hit = wr && (addr == '0);

  always_ff @(posedge clk) begin
    if (rst) en <= 1'b0;
    else if (ctrl_hit && wmask[EN_BIT]) en <= wdata[EN_BIT];
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam int unsigned SADDR = SEL_BASE + (n / 2) * 4;
    localparam int unsigned SLSB  = (n % 2) * ODD_LSB;
    logic sel_hit;
    logic [SELW-1:0] m;
    assign sel_hit = wr && (addr == AW'(SADDR));
    assign m       = wmask[SLSB +: SELW];

    always_ff @(posedge clk) begin
      if (rst) begin
        both[n] <= 1'b0;
        edg[n]  <= 1'b0;
        pol[n]  <= 1'b0;
        sel[n]  <= '0;
      end else begin
        if (ctrl_hit && wmask[BOTH_LSB + n]) both[n] <= wdata[BOTH_LSB + n];
        if (ctrl_hit && wmask[EDGE_LSB + n]) edg[n]  <= wdata[EDGE_LSB + n];
        if (ctrl_hit && wmask[POL_LSB + n])  pol[n]  <= wdata[POL_LSB + n];
        if (sel_hit) sel[n] <= (sel[n] & ~m) | (wdata[SLSB +: SELW] & m);
      end
    end

    assign touch[n] = (ctrl_hit && (wmask[BOTH_LSB + n] || wmask[EDGE_LSB + n]
                                    || wmask[POL_LSB + n]))
                      || (sel_hit && (|m));
  end

  always_comb begin
    rd_next = '0;
    if (addr == '0) begin
      rd_next[EN_BIT] = en;
      for (int n = 0; n < NCH; n++) begin
        rd_next[BOTH_LSB + n] = both[n];
        rd_next[EDGE_LSB + n] = edg[n];
        rd_next[POL_LSB + n]  = pol[n];
      end
    end
    for (int n = 0; n < NCH; n++) begin
      if (addr == AW'(SEL_BASE + (n / 2) * 4))
        rd_next[(n % 2) * ODD_LSB +: SELW] = sel[n];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  // R8
  en_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == '0 && wmask[EN_BIT]) |=> (en == $past(wdata[EN_BIT])));
endmodule

// File: rtl/irq_channel.sv
module irq_channel #(
  parameter int unsigned NPADS = 62,
  parameter int unsigned SELW  = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPADS-1:0] pads_s,
  input  logic             en,
  input  logic             both,
  input  logic             edg,
  input  logic             pol,
  input  logic [SELW-1:0]  sel,
  input  logic             touch,
  output logic             irq
);
  logic valid, cur, prev, quiet, rise, fall, fire;

  assign valid = (int'(sel) < int'(NPADS));
  assign cur   = valid && pads_s[sel];
  assign rise  = !quiet && !prev && cur;
  assign fall  = !quiet && prev && !cur;

  always_comb begin
    if (!valid)    fire = 1'b0;
    else if (both) fire = rise || fall;
    else if (edg)  fire = pol ? fall : rise;
    else           fire = cur ^ pol;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev  <= 1'b0;
      quiet <= 1'b0;
      irq   <= 1'b0;
    end else begin
      prev  <= cur;
      quiet <= touch;
      irq   <= en && fire;
    end
  end

  // R7
  bad_sel_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |=> !irq);

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !both && edg) |=> !(irq && !both && edg));
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPADS = NUM_PADS,
  parameter int unsigned NCH   = NUM_CH,
  parameter int unsigned SELW  = SEL_W,
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned DW    = DATA_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPADS-1:0] pad_in,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic [DW-1:0]    bus_wmask,
  output logic [DW-1:0]    bus_rdata,
  output logic [NCH-1:0]   irq_out
);
  logic [NPADS-1:0]          pads_s;
  logic                      en;
  logic [NCH-1:0]            both, edg, pol, touch;
  logic [NCH-1:0][SELW-1:0]  sel;

  irq_pad_sync #(.WIDTH(NPADS)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pads_s)
  );

  irq_regfile #(.NCH(NCH), .SELW(SELW), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .wmask(bus_wmask), .rdata(bus_rdata), .en(en), .both(both), .edg(edg),
    .pol(pol), .sel(sel), .touch(touch)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    irq_channel #(.NPADS(NPADS), .SELW(SELW)) u_ch (
      .clk(clk), .rst(rst), .pads_s(pads_s), .en(en), .both(both[n]),
      .edg(edg[n]), .pol(pol[n]), .sel(sel[n]), .touch(touch[n]),
      .irq(irq_out[n])
    );
  end

  // R2
  en_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (irq_out == '0));
endmodule

// File: tb/sim_gpio_irq_router.sv
module sim_gpio_irq_router;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [61:0] pad_in = '0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_wmask = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  irq_out;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  gpio_irq_router u0 (
    .clk(clk), .rst(rst), .pad_in(pad_in), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wmask(bus_wmask), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [31:0] m);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wmask = m;
    step(1);
    bus_wr = 1'b0; bus_wmask = '0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    bus_addr = a;
    step(1);
    check(req, bus_rdata, exp);
  endtask

  task automatic t_reset;
    for (int a = 0; a <= 16; a += 4) rd_chk("R1", 5'(a), 32'h0);
    check("R1", {24'h0, irq_out}, 32'h0);
  endtask

  task automatic t_regs;
    wr(5'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rd_chk("R9", 5'h00, 32'h80FF_FFFF);
    wr(5'h08, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rd_chk("R9", 5'h08, 32'h007F_007F);
    rd_chk("R9", 5'h14, 32'h0);
    wr(5'h00, 32'h0, 32'h0000_0101);
    rd_chk("R8", 5'h00, 32'h80FF_FEFE);
    wr(5'h08, 32'h0, 32'h0000_007F);
    rd_chk("R8", 5'h08, 32'h007F_0000);
    wr(5'h00, 32'h0, 32'hFFFF_FFFF);
    wr(5'h08, 32'h0, 32'hFFFF_FFFF);
    step(3);
  endtask

  task automatic t_route;
    // R6: channel n -> pad 7n+3
    for (int n = 0; n < 8; n++)
      wr(5'(4 + (n / 2) * 4), 32'(7 * n + 3) << ((n % 2) * 16), 32'h7F << ((n % 2) * 16));
    rd_chk("R6", 5'h08, 32'h0018_0011);
    wr(5'h00, 32'h8000_0000, 32'hFFFF_FFFF);
    pad_in = '0;
    pad_in[24] = 1'b1;
    step(2);
    check("R10", {24'h0, irq_out}, 32'h0);
    step(1);
    check("R6", {24'h0, irq_out}, 32'h08);
    wr(5'h00, 32'h0000_00FF, 32'h0000_00FF);
    step(1);
    check("R3", {24'h0, irq_out}, 32'hF7);
    wr(5'h00, 32'h0, 32'h8000_0000);
    step(1);
    check("R2", {24'h0, irq_out}, 32'h0);
    step(3);
    check("R2", {24'h0, irq_out}, 32'h0);
    pad_in = '0;
    wr(5'h00, 32'h0, 32'hFFFF_FFFF);
    step(3);
  endtask

  task automatic t_edges;
    wr(5'h04, 32'h0000_0003, 32'h0000_007F);
    wr(5'h00, 32'h8000_0100, 32'hFFFF_FFFF);
    step(3);
    check("R4", {31'h0, irq_out[0]}, 32'h0);
    pad_in[3] = 1'b1;
    step(3);
    check("R4", {31'h0, irq_out[0]}, 32'h1);
    step(1);
    check("R4", {31'h0, irq_out[0]}, 32'h0);
    pad_in[3] = 1'b0;
    step(4);
    check("R4", {31'h0, irq_out[0]}, 32'h0);
    wr(5'h00, 32'h0000_0001, 32'h0000_0001);
    step(3);
    pad_in[3] = 1'b1;
    step(4);
    check("R4", {31'h0, irq_out[0]}, 32'h0);
    pad_in[3] = 1'b0;
    step(3);
    check("R4", {31'h0, irq_out[0]}, 32'h1);
    step(1);
    check("R4", {31'h0, irq_out[0]}, 32'h0);
    // R5: both-edge with edge=0 pol=1 (level-low would be active)
    wr(5'h00, 32'h8001_0001, 32'hFFFF_FFFF);
    step(3);
    check("R5", {31'h0, irq_out[0]}, 32'h0);
    pad_in[3] = 1'b1;
    step(3);
    check("R5", {31'h0, irq_out[0]}, 32'h1);
    step(1);
    check("R5", {31'h0, irq_out[0]}, 32'h0);
    pad_in[3] = 1'b0;
    step(3);
    check("R5", {31'h0, irq_out[0]}, 32'h1);
    step(1);
    check("R5", {31'h0, irq_out[0]}, 32'h0);
  endtask

  task automatic t_badsel;
    wr(5'h04, 32'h003F_0000, 32'h007F_0000);
    wr(5'h00, 32'h8000_0002, 32'hFFFF_FFFF);
    pad_in = '0;
    step(4);
    check("R7", {31'h0, irq_out[1]}, 32'h0);
    wr(5'h04, 32'h003E_0000, 32'h007F_0000);
    pad_in = '1;
    step(4);
    check("R7", {31'h0, irq_out[1]}, 32'h0);
    pad_in = '0;
    wr(5'h00, 32'h0, 32'hFFFF_FFFF);
    step(3);
  endtask

  task automatic t_switch;
    logic seen = 1'b0;
    wr(5'h04, 32'h0000_0000, 32'h0000_007F);
    wr(5'h00, 32'h8000_0100, 32'hFFFF_FFFF);
    pad_in = '0;
    pad_in[5] = 1'b1;
    step(4);
    check("R11", {31'h0, irq_out[0]}, 32'h0);
    wr(5'h04, 32'h0000_0005, 32'h0000_007F);
    for (int i = 0; i < 6; i++) begin
      if (irq_out[0]) seen = 1'b1;
      step(1);
    end
    check("R11", {31'h0, seen}, 32'h0);
  endtask

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_regs();
    t_route();
    t_edges();
    t_badsel();
    t_switch();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule